// File: doc/BRIEF.md
# BCD Calendar Clock with 12/24-Hour Hour Encoding

This block keeps wall-clock time and calendar date in seven packed-BCD registers: seconds, minutes, hour, weekday, day of month, month and a two-digit year. It is advanced by a free-running base strobe. An internal prescaler divides that strobe down to a one-second step. Each second step carries through seconds, minutes and hours into the date fields. The day-of-month limit depends on the month, and February follows a divisible-by-four leap rule.

The hour register has two encodings, chosen by a mode input. In 24-hour mode it holds BCD 00 to 23. In 12-hour mode it holds BCD 1 to 12 in the low five bits, with bit 5 as the afternoon flag. Software loads any register through a single-register write port. That write also restarts the prescaler. A combinational read port shows any register by its index. A sticky time-invalid flag is set at reset and whenever the oscillator-loss input pulses. Software clears it through a separate clear input once it has written a good time.

Top module: `bcd_calendar_core`

## Requirements
- R1: Register index 0 holds seconds, 1 minutes, 2 hour, 3 weekday, 4 day of month, 5 month and 6 year. Reading index 7 returns 0x00. After reset the time reads 00:00:00, weekday 0, day 01, month 01, year 00.
- R2: A write stores only the valid bits of the addressed field: 7 bits for seconds and minutes, 6 for the hour, 3 for the weekday, 6 for the day, 5 for the month and all 8 for the year. The remaining bits read back as 0. The new value is readable on the cycle after the write.
- R3: On a second step, seconds go from 0x59 to 0x00 and step the minutes. Minutes go from 0x59 to 0x00 and step the hour.
- R4: In 24-hour mode (mode input high), hour 0x23 wraps to 0x00 and advances both the day of month and the weekday.
- R5: In 12-hour mode (mode input low, bit 5 = afternoon), the hour steps 0x11→0x32 at noon, 0x32→0x21 and 0x31→0x12. That last step is midnight and advances the date. The step 0x12→0x01 keeps the afternoon flag and leaves the date alone. All other hours count in BCD.
- R6: Day 0x30 ends April, June, September and November. Day 0x31 ends every other month except February. After the last day comes day 0x01 of the next month. Month 0x12 wraps to 0x01 and steps the year, and year 0x99 wraps to 0x00.
- R7: February ends on day 0x29 when the binary year is divisible by four (00, 24 and 96, for example), and on day 0x28 otherwise.
- R8: The weekday counts 0 to 6 and wraps from 6 to 0 on each day advance.
- R9: A second step happens on every TICKS_PER_SEC-th base strobe. Any write restarts this count, so the next step comes only after a further TICKS_PER_SEC strobes.
- R10: Changing the mode input leaves the stored hour value as it is.
- R11: The time-invalid output is 1 after reset and is set by an oscillator-loss pulse. A clear pulse resets it to 0. When both arrive in the same cycle, the set wins.
- R12: The time registers change only on a second step or a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_tick | input | 1 | Sub-second base strobe, one cycle per pulse |
| hour24_mode | input | 1 | 1 = 24-hour hour encoding, 0 = 12-hour with afternoon flag |
| wr_en | input | 1 | Write strobe for one time register |
| wr_addr | input | 3 | Index of the register to write (0 to 6) |
| wr_data | input | 8 | BCD value to write |
| rd_addr | input | 3 | Index of the register to show |
| rd_data | output | 8 | Contents of the selected register, combinational |
| osc_lost | input | 1 | Pulse marking a timing interruption; sets the invalid flag |
| stop_clr | input | 1 | Pulse that clears the invalid flag |
| time_invalid | output | 1 | Sticky flag: the stored time is not trustworthy |

## Verification
The stimulus loads times just before each boundary, and then gives one second step. That separates carries inside a field from rollovers that cross into the next field. The 59-second, 59-minute, 23-hour case on 31 December 99 drives a carry through every field at once. February is tried with years 00, 23, 24, 96 and 98, which separates the leap decision for odd and even tens digits. Thirty-day and thirty-one-day months are tried at day 30, which separates the two month-length groups. In 12-hour mode the hours 09, 11, 12, 29, 31 and 32 are tried, which separates the plain BCD steps, the noon flip and the midnight date advance. Partial base-strobe runs with a write in the middle show whether a write restarts the prescaler.

// File: rtl/cal_pkg.sv
`timescale 1ns/1ps
package cal_pkg;

    localparam int unsigned ADDR_W = 3;
    localparam int unsigned DATA_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_WDAY  = 3'd3,
        F_DAY   = 3'd4,
        F_MONTH = 3'd5,
        F_YEAR  = 3'd6
    } field_e;

    localparam logic [DATA_W-1:0] MASK_SEC   = 8'h7F;
    localparam logic [DATA_W-1:0] MASK_MIN   = 8'h7F;
    localparam logic [DATA_W-1:0] MASK_HOUR  = 8'h3F;
    localparam logic [DATA_W-1:0] MASK_WDAY  = 8'h07;
    localparam logic [DATA_W-1:0] MASK_DAY   = 8'h3F;
    localparam logic [DATA_W-1:0] MASK_MONTH = 8'h1F;
    localparam logic [DATA_W-1:0] MASK_YEAR  = 8'hFF;

    localparam logic [DATA_W-1:0] LAST_WDAY  = 8'h06;

    typedef struct packed {
        logic [DATA_W-1:0] sec;
        logic [DATA_W-1:0] min;
        logic [DATA_W-1:0] hour;
        logic [DATA_W-1:0] wday;
        logic [DATA_W-1:0] day;
        logic [DATA_W-1:0] month;
        logic [DATA_W-1:0] year;
    } cal_time_t;

    typedef struct packed {
        logic [DATA_W-1:0] hour;
        logic              wrap;
    } hour_step_t;

    function automatic logic [DATA_W-1:0] field_mask(input logic [ADDR_W-1:0] a);
        case (a)
            F_SEC:   return MASK_SEC;
            F_MIN:   return MASK_MIN;
            F_HOUR:  return MASK_HOUR;
            F_WDAY:  return MASK_WDAY;
            F_DAY:   return MASK_DAY;
            F_MONTH: return MASK_MONTH;
            F_YEAR:  return MASK_YEAR;
            default: return '0;
        endcase
    endfunction

    // Two-digit packed BCD increment (no range check).
    function automatic logic [DATA_W-1:0] bcd_inc(input logic [DATA_W-1:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // (10*t + o) mod 4 equals (2*t + o) mod 4.
    function automatic logic leap_year(input logic [DATA_W-1:0] y);
        logic [4:0] s;
        s = {y[7:4], 1'b0} + {1'b0, y[3:0]};
        return s[1:0] == 2'b00;
    endfunction

    function automatic logic [DATA_W-1:0] month_last_day(input logic [DATA_W-1:0] m,
                                                         input logic [DATA_W-1:0] y);
        case (m)
            8'h02:                      return leap_year(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

    function automatic hour_step_t next_hour(input logic [DATA_W-1:0] h, input logic mode24);
        hour_step_t r;
        logic [4:0] low;
        r.hour = bcd_inc(h);
        r.wrap = 1'b0;
        low    = 5'(bcd_inc({3'b000, h[4:0]}));
        if (mode24) begin
            if (h == 8'h23) begin
                r.hour = 8'h00;
                r.wrap = 1'b1;
            end
        end else begin
            if (h[4:0] == 5'h12) begin
                r.hour = {2'b00, h[5], 5'h01};
            end else if (h[4:0] == 5'h11) begin
                r.hour = {2'b00, ~h[5], 5'h12};
                r.wrap = h[5];
            end else begin
                r.hour = {2'b00, h[5], low};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/cal_prescaler.sv
`timescale 1ns/1ps
module cal_prescaler #(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst,
    input  logic base_tick,
    input  logic restart,
    output logic sec_step
);
    localparam int unsigned CNT_W = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_SEC - 1);

    logic [CNT_W-1:0] cnt;

    assign sec_step = base_tick && (cnt == LAST) && !restart;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (base_tick) begin
            if (cnt == LAST)
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/cal_mod60.sv
`timescale 1ns/1ps
module cal_mod60
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              carry_in,
    input  logic              load,
    input  logic [DATA_W-1:0] load_val,
    output logic [DATA_W-1:0] q,
    output logic              carry_out
);
    localparam logic [DATA_W-1:0] TOP = 8'h59;

    assign carry_out = carry_in && (q == TOP);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= load_val;
        else if (carry_in)
            q <= (q == TOP) ? '0 : bcd_inc(q);
    end
endmodule

// File: rtl/cal_hms.sv
`timescale 1ns/1ps
module cal_hms
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_step,
    input  logic              mode24,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] sec_q,
    output logic [DATA_W-1:0] min_q,
    output logic [DATA_W-1:0] hour_q,
    output logic              day_carry
);
    localparam int unsigned N_SEXA = 2;

    logic [N_SEXA:0]   chain;
    logic [DATA_W-1:0] sexa_q [N_SEXA];
    hour_step_t        hstep;

    assign chain[0] = sec_step;

    for (genvar g = 0; g < N_SEXA; g++) begin : g_sexa
        cal_mod60 u_cnt (
            .clk       (clk),
            .rst       (rst),
            .carry_in  (chain[g]),
            .load      (wr_en && (wr_addr == ADDR_W'(g))),
            .load_val  (wr_val),
            .q         (sexa_q[g]),
            .carry_out (chain[g+1])
        );
    end

    assign sec_q = sexa_q[0];
    assign min_q = sexa_q[1];

    assign hstep     = next_hour(hour_q, mode24);
    assign day_carry = chain[N_SEXA] && hstep.wrap;

    always_ff @(posedge clk) begin
        if (rst)
            hour_q <= '0;
        else if (wr_en && (wr_addr == F_HOUR))
            hour_q <= wr_val;
        else if (chain[N_SEXA])
            hour_q <= hstep.hour;
    end
endmodule

// File: rtl/cal_date.sv
`timescale 1ns/1ps
module cal_date
    import cal_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              day_carry,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_val,
    output logic [DATA_W-1:0] wday_q,
    output logic [DATA_W-1:0] day_q,
    output logic [DATA_W-1:0] month_q,
    output logic [DATA_W-1:0] year_q
);
    logic month_end;
    logic year_end;

    assign month_end = day_carry && (day_q == month_last_day(month_q, year_q));
    assign year_end  = month_end && (month_q == 8'h12);

    always_ff @(posedge clk) begin
        if (rst)
            wday_q <= '0;
        else if (wr_en && (wr_addr == F_WDAY))
            wday_q <= wr_val;
        else if (day_carry)
            wday_q <= (wday_q >= LAST_WDAY) ? '0 : wday_q + 8'd1;
    end

    always_ff @(posedge clk) begin
        if (rst)
            day_q <= 8'h01;
        else if (wr_en && (wr_addr == F_DAY))
            day_q <= wr_val;
        else if (month_end)
            day_q <= 8'h01;
        else if (day_carry)
            day_q <= bcd_inc(day_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            month_q <= 8'h01;
        else if (wr_en && (wr_addr == F_MONTH))
            month_q <= wr_val;
        else if (year_end)
            month_q <= 8'h01;
        else if (month_end)
            month_q <= bcd_inc(month_q);
    end

    always_ff @(posedge clk) begin
        if (rst)
            year_q <= '0;
        else if (wr_en && (wr_addr == F_YEAR))
            year_q <= wr_val;
        else if (year_end)
            year_q <= (year_q == 8'h99) ? '0 : bcd_inc(year_q);
    end
endmodule

// File: rtl/cal_stop_flag.sv
`timescale 1ns/1ps
module cal_stop_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_in,
    input  logic clr_in,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || set_in)
            flag <= 1'b1;
        else if (clr_in)
            flag <= 1'b0;
    end
endmodule

// File: rtl/bcd_calendar_core.sv
`timescale 1ns/1ps
module bcd_calendar_core
    import cal_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 32768
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        base_tick,
    input  logic        hour24_mode,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    input  logic        osc_lost,
    input  logic        stop_clr,
    output logic        time_invalid
);
    logic              adv;
    logic              day_carry;
    logic [DATA_W-1:0] wr_val;
    cal_time_t         cur;

    assign wr_val = wr_data & field_mask(wr_addr);

    cal_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_presc (
        .clk       (clk),
        .rst       (rst),
        .base_tick (base_tick),
        .restart   (wr_en),
        .sec_step  (adv)
    );

    cal_hms u_hms (
        .clk       (clk),
        .rst       (rst),
        .sec_step  (adv),
        .mode24    (hour24_mode),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_val    (wr_val),
        .sec_q     (cur.sec),
        .min_q     (cur.min),
        .hour_q    (cur.hour),
        .day_carry (day_carry)
    );

    cal_date u_date (
        .clk       (clk),
        .rst       (rst),
        .day_carry (day_carry),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_val    (wr_val),
        .wday_q    (cur.wday),
        .day_q     (cur.day),
        .month_q   (cur.month),
        .year_q    (cur.year)
    );

    cal_stop_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_in (osc_lost),
        .clr_in (stop_clr),
        .flag   (time_invalid)
    );

    always_comb begin
        case (rd_addr)
            F_SEC:   rd_data = cur.sec;
            F_MIN:   rd_data = cur.min;
            F_HOUR:  rd_data = cur.hour;
            F_WDAY:  rd_data = cur.wday;
            F_DAY:   rd_data = cur.day;
            F_MONTH: rd_data = cur.month;
            F_YEAR:  rd_data = cur.year;
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/cal_core_checker.sv
`timescale 1ns/1ps
module cal_core_checker
    import cal_pkg::*;
#(
    parameter int unsigned TPS = 32768
) (
    input logic      clk,
    input logic      rst,
    input logic      adv,
    input logic      mode24,
    input logic      wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic      osc_lost,
    input logic      stop_clr,
    input logic      time_invalid,
    input cal_time_t cur
);
    assert_load_year_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en && (wr_addr == 3'd6) |=> cur.year == $past(wr_data));

    assert_sec_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        adv && (cur.sec == 8'h59) |=> cur.sec == 8'h00);

    assert_min_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        adv && (cur.sec == 8'h59) && (cur.min == 8'h59) |=> cur.min == 8'h00);

    assert_midnight_R4: assert property (@(posedge clk) disable iff (rst)
        adv && mode24 && (cur.sec == 8'h59) && (cur.min == 8'h59) && (cur.hour == 8'h23)
        |=> (cur.hour == 8'h00) && (cur.day != $past(cur.day)));

    assert_noon_R5: assert property (@(posedge clk) disable iff (rst)
        adv && !mode24 && (cur.sec == 8'h59) && (cur.min == 8'h59) && (cur.hour == 8'h11)
        |=> cur.hour == 8'h32);

    assert_restart_R9: assert property (@(posedge clk) disable iff (rst)
        (TPS > 1) && wr_en |=> !adv);

    assert_flag_set_R11: assert property (@(posedge clk) disable iff (rst)
        osc_lost |=> time_invalid);

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
        stop_clr && !osc_lost |=> !time_invalid);

    assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
        !wr_en && !adv |=> $stable(cur));
endmodule

bind bcd_calendar_core cal_core_checker #(.TPS(TICKS_PER_SEC)) i_chk (
    .clk          (clk),
    .rst          (rst),
    .adv          (adv),
    .mode24       (hour24_mode),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .osc_lost     (osc_lost),
    .stop_clr     (stop_clr),
    .time_invalid (time_invalid),
    .cur          (cur)
);

// File: tb/test_bcd_calendar_core.sv
`timescale 1ns/1ps
module test_bcd_calendar_core;
    localparam int TPS = 4;
    localparam logic [3:0] FLAG_IDX = 4'd8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       base_tick = 1'b0;
    logic       hour24_mode = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       osc_lost = 1'b0;
    logic       stop_clr = 1'b0;
    logic       time_invalid;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [3:0] q_idx [$];
    logic [7:0] q_exp [$];
    string      q_tag [$];

    always #10 clk = ~clk;

    bcd_calendar_core #(.TICKS_PER_SEC(TPS)) i_bcd_calendar_core (
        .clk(clk), .rst(rst), .base_tick(base_tick), .hour24_mode(hour24_mode),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .osc_lost(osc_lost), .stop_clr(stop_clr), .time_invalid(time_invalid)
    );

    // Monitor: pops expected items and compares them with the ports.
    initial begin
        logic [7:0] got;
        forever begin
            @(negedge clk);
            if (q_idx.size() != 0) begin
                if (q_idx[0] == FLAG_IDX) begin
                    got = {7'd0, time_invalid};
                end else begin
                    rd_addr = q_idx[0][2:0];
                    #2;
                    got = rd_data;
                end
                total++;
                if (got !== q_exp[0]) begin
                    bad++;
                    $display("FAIL %s: index %0d actual %h expected %h", q_tag[0], q_idx[0], got, q_exp[0]);
                end
                void'(q_idx.pop_front());
                void'(q_exp.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    task automatic check(input logic [3:0] idx, input logic [7:0] exp, input string tag);
        q_idx.push_back(idx);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
        while (q_idx.size() != 0) @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); base_tick = 1'b1;
            @(negedge clk); base_tick = 1'b0;
        end
    endtask

    task automatic seconds(input int n);
        ticks(n * TPS);
    endtask

    task automatic set_all(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                           input logic [7:0] w, input logic [7:0] d, input logic [7:0] mo,
                           input logic [7:0] y);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, w);
        wr(3'd4, d); wr(3'd5, mo); wr(3'd6, y);
    endtask

    task automatic feb_case(input logic [7:0] y, input logic [7:0] exp_day, input logic [7:0] exp_mon);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, y);
        seconds(1);
        check(4'd4, exp_day, "R7 feb day");
        check(4'd5, exp_mon, "R7 feb month");
    endtask

    task automatic hour12_case(input logic [7:0] h, input logic [7:0] exp_h, input logic [7:0] exp_day);
        set_all(8'h59, 8'h59, h, 8'h02, 8'h15, 8'h03, 8'h10);
        seconds(1);
        check(4'd2, exp_h, "R5 12h hour step");
        check(4'd4, exp_day, "R5 12h day");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state and register order
        check(4'd0, 8'h00, "R1 reset sec");
        check(4'd1, 8'h00, "R1 reset min");
        check(4'd2, 8'h00, "R1 reset hour");
        check(4'd3, 8'h00, "R1 reset wday");
        check(4'd4, 8'h01, "R1 reset day");
        check(4'd5, 8'h01, "R1 reset month");
        check(4'd6, 8'h00, "R1 reset year");
        check(4'd7, 8'h00, "R1 unused index");
        check(FLAG_IDX, 8'h01, "R11 flag after reset");

        // R1/R2 field order and masking
        set_all(8'h12, 8'h34, 8'h15, 8'h04, 8'h27, 8'h08, 8'h45);
        check(4'd1, 8'h34, "R1 min index");
        check(4'd5, 8'h08, "R1 month index");
        for (int a = 0; a < 7; a++) wr(3'(a), 8'hFF);
        check(4'd0, 8'h7F, "R2 sec mask");
        check(4'd1, 8'h7F, "R2 min mask");
        check(4'd2, 8'h3F, "R2 hour mask");
        check(4'd3, 8'h07, "R2 wday mask");
        check(4'd4, 8'h3F, "R2 day mask");
        check(4'd5, 8'h1F, "R2 month mask");
        check(4'd6, 8'hFF, "R2 year mask");

        // R9/R12 prescaler and write restart
        set_all(8'h10, 8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00);
        ticks(TPS - 1);
        check(4'd0, 8'h10, "R12 no change before full second");
        ticks(1);
        check(4'd0, 8'h11, "R9 step on last base tick");
        ticks(2);
        wr(3'd1, 8'h05);
        ticks(TPS - 1);
        check(4'd0, 8'h11, "R9 write restarts prescaler");
        ticks(1);
        check(4'd0, 8'h12, "R9 step after restart");
        check(4'd1, 8'h05, "R12 min kept");

        // R3/R4/R6/R8 full cascade
        set_all(8'h58, 8'h59, 8'h23, 8'h06, 8'h31, 8'h12, 8'h99);
        seconds(1);
        check(4'd0, 8'h59, "R3 plain second step");
        check(4'd1, 8'h59, "R3 min unchanged");
        seconds(1);
        check(4'd0, 8'h00, "R3 sec wrap");
        check(4'd1, 8'h00, "R3 min wrap");
        check(4'd2, 8'h00, "R4 hour wrap 24h");
        check(4'd3, 8'h00, "R8 weekday wrap");
        check(4'd4, 8'h01, "R6 day wrap");
        check(4'd5, 8'h01, "R6 month wrap");
        check(4'd6, 8'h00, "R6 year wrap");

        // R4 weekday advance mid-week
        set_all(8'h59, 8'h59, 8'h23, 8'h02, 8'h10, 8'h05, 8'h20);
        seconds(1);
        check(4'd3, 8'h03, "R4 weekday advance");
        check(4'd4, 8'h11, "R4 day advance");

        // R6 month lengths
        set_all(8'h59, 8'h59, 8'h23, 8'h00, 8'h30, 8'h04, 8'h10);
        seconds(1);
        check(4'd4, 8'h01, "R6 april end day");
        check(4'd5, 8'h05, "R6 april end month");
        set_all(8'h59, 8'h59, 8'h23, 8'h00, 8'h30, 8'h09, 8'h10);
        seconds(1);
        check(4'd5, 8'h10, "R6 september end month");
        set_all(8'h59, 8'h59, 8'h23, 8'h00, 8'h30, 8'h01, 8'h10);
        seconds(1);
        check(4'd4, 8'h31, "R6 january day 31");
        check(4'd5, 8'h01, "R6 january month");

        // R7 leap rule
        feb_case(8'h24, 8'h29, 8'h02);
        feb_case(8'h23, 8'h01, 8'h03);
        feb_case(8'h00, 8'h29, 8'h02);
        feb_case(8'h96, 8'h29, 8'h02);
        feb_case(8'h98, 8'h01, 8'h03);
        set_all(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h24);
        seconds(1);
        check(4'd4, 8'h01, "R7 leap feb 29 end");
        check(4'd5, 8'h03, "R7 leap feb end month");

        // R5 12-hour sequence
        @(negedge clk); hour24_mode = 1'b0;
        hour12_case(8'h11, 8'h32, 8'h15);
        hour12_case(8'h32, 8'h21, 8'h15);
        hour12_case(8'h31, 8'h12, 8'h16);
        hour12_case(8'h12, 8'h01, 8'h15);
        hour12_case(8'h09, 8'h10, 8'h15);
        hour12_case(8'h29, 8'h30, 8'h15);

        // R10 mode change keeps the stored hour
        wr(3'd2, 8'h21);
        @(negedge clk); hour24_mode = 1'b1;
        check(4'd2, 8'h21, "R10 hour unchanged to 24h");
        @(negedge clk); hour24_mode = 1'b0;
        check(4'd2, 8'h21, "R10 hour unchanged to 12h");
        @(negedge clk); hour24_mode = 1'b1;

        // R11 invalid flag
        @(negedge clk); stop_clr = 1'b1;
        @(negedge clk); stop_clr = 1'b0;
        check(FLAG_IDX, 8'h00, "R11 clear");
        @(negedge clk); osc_lost = 1'b1;
        @(negedge clk); osc_lost = 1'b0;
        check(FLAG_IDX, 8'h01, "R11 set by loss");
        @(negedge clk); osc_lost = 1'b1; stop_clr = 1'b1;
        @(negedge clk); osc_lost = 1'b0; stop_clr = 1'b0;
        check(FLAG_IDX, 8'h01, "R11 set wins");
        @(negedge clk); stop_clr = 1'b1;
        @(negedge clk); stop_clr = 1'b0;
        check(FLAG_IDX, 8'h00, "R11 clear again");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule